// File: doc/BRIEF.md
# Width-Matching Synchronous Byte FIFO

This block is a single-clock first-in first-out buffer whose write side and read side each run at either 9 or 18 bits. Storage is a row of 9-bit lanes. A wide write drops two lanes into the queue and a wide read takes two lanes out. This lets a narrow producer feed a wide consumer, or a wide producer feed a narrow consumer, through one queue with no glue logic around it.

The two port widths and a byte-order selection are sampled on every clock while master reset is high. They then stay frozen until master reset is asserted again. The byte-order selection decides which half of an 18-bit word is the earlier byte in the queue. This applies both when a wide word is split into lanes and when lanes are joined into a wide word.

The total capacity is fixed in lanes. The capacity in words is therefore halved when the write side is 18 bits wide. The read data is registered. The full and empty flags are computed from the number of lanes stored compared with the size of one port word.

Top module: `bmf_fifo`

## Requirements
- R1: While `mrst` is high, and on the first cycle after it falls, `empty` is 1, `full` is 0 and `rd_data` is 0.
- R2: `cfg_in_wide`, `cfg_out_wide` and `cfg_big_end` are sampled only on clock edges where `mrst` is high. Changing them while `mrst` is low has no effect on how data is stored or returned.
- R3: With both ports 18 bits wide, each word comes out unchanged and in the order it was written, whatever the value of `cfg_big_end`.
- R4: With both ports 9 bits wide, each byte on `wr_data[8:0]` comes out on `rd_data[8:0]` in write order.
- R5: With an 18-bit write side and a 9-bit read side, each stored word is returned as two consecutive reads. With `cfg_big_end`=1 the first read returns bits [17:9] and the second returns bits [8:0]. With `cfg_big_end`=0 the order is reversed.
- R6: With a 9-bit write side and an 18-bit read side, two consecutive writes form one read word. With `cfg_big_end`=1 the first byte written lands in `rd_data[17:9]`. With `cfg_big_end`=0 it lands in `rd_data[8:0]`.
- R7: `empty` is 1 exactly when fewer lanes are stored than one read word needs (1 lane for a 9-bit read side, 2 lanes for an 18-bit read side).
- R8: `full` is 1 exactly when fewer than one write word of lanes is free (1 lane for a 9-bit write side, 2 lanes for an 18-bit write side). The capacity is `DEPTH_LANES` lanes.
- R9: A write while `full` is 1 is dropped. A read while `empty` is 1 is dropped, and `rd_data` keeps its value. Neither case moves a pointer.
- R10: `rd_data` changes only on the clock edge that accepts a read, and it shows that read's word after that edge. With a 9-bit read side, `rd_data[17:9]` is 0.
- R11: A write and a read accepted on the same edge both take effect, and the lane count changes by the difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| mrst | input | 1 | Synchronous master reset, active high; configuration is sampled while it is high |
| cfg_in_wide | input | 1 | 1 = write side 18 bits, 0 = write side 9 bits |
| cfg_out_wide | input | 1 | 1 = read side 18 bits, 0 = read side 9 bits |
| cfg_big_end | input | 1 | 1 = earlier byte in bits [17:9], 0 = earlier byte in bits [8:0] |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word; only [8:0] is used when the write side is 9 bits |
| rd_en | input | 1 | Read request |
| rd_data | output | 18 | Registered read word |
| full | output | 1 | No room for one write word |
| empty | output | 1 | Less than one read word stored |

## Verification
The assertions assume that master reset is held high on the first clock edge, so that the configuration and pointer registers start out defined. They also assume that the configuration inputs are meaningful on every edge where master reset is high. The bench holds reset across two edges with the configuration already settled. It drives all inputs half a cycle away from the active edge. Immediately after releasing reset, it flips every configuration input, so the latched setting is the only one that can explain the observed byte order.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

    localparam int unsigned LANE_W = 9;
    localparam int unsigned WORD_W = 2 * LANE_W;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic in_wide;
        logic out_wide;
        logic big_end;
    } bmf_cfg_t;

    // Earlier lane in queue order taken from a wide word.
    function automatic lane_t lead_lane(input word_t w, input logic big);
        return big ? w[WORD_W-1:LANE_W] : w[LANE_W-1:0];
    endfunction

    // Later lane in queue order taken from a wide word.
    function automatic lane_t trail_lane(input word_t w, input logic big);
        return big ? w[LANE_W-1:0] : w[WORD_W-1:LANE_W];
    endfunction

    // Join two lanes, earlier one first, into a wide word.
    function automatic word_t join_lanes(input lane_t early, input lane_t late, input logic big);
        return big ? {early, late} : {late, early};
    endfunction

endpackage

// File: rtl/bmf_cfg_latch.sv
module bmf_cfg_latch
    import bmf_pkg::*;
(
    input  logic     clk,
    input  logic     mrst,
    input  bmf_cfg_t cfg_in,
    output bmf_cfg_t cfg
);

    bmf_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mrst) begin
            cfg_d = cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R2: outside master reset the setting is frozen
    assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (mrst)
        1'b1 |=> $stable(cfg_q));

endmodule

// File: rtl/bmf_lane_store.sv
module bmf_lane_store
    import bmf_pkg::*;
#(
    parameter int unsigned DEPTH_LANES = 64,
    localparam int unsigned AW = $clog2(DEPTH_LANES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          we_pair,
    input  logic [AW-1:0] waddr,
    input  lane_t         wlane0,
    input  lane_t         wlane1,
    input  logic [AW-1:0] raddr,
    output lane_t         rlane0,
    output lane_t         rlane1
);

    lane_t         lanes [DEPTH_LANES];
    logic [AW-1:0] waddr_nx;
    logic [AW-1:0] raddr_nx;

    assign waddr_nx = waddr + AW'(1);
    assign raddr_nx = raddr + AW'(1);

    for (genvar g = 0; g < DEPTH_LANES; g++) begin : g_lane
        lane_t lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (we && waddr == AW'(g)) begin
                lane_d = wlane0;
            end else if (we && we_pair && waddr_nx == AW'(g)) begin
                lane_d = wlane1;
            end
        end

        always_ff @(posedge clk) begin
            lane_q <= lane_d;
        end

        assign lanes[g] = lane_q;
    end

    assign rlane0 = lanes[raddr];
    assign rlane1 = lanes[raddr_nx];

endmodule

// File: rtl/bmf_ptr_ctrl.sv
module bmf_ptr_ctrl #(
    parameter int unsigned DEPTH_LANES = 64,
    localparam int unsigned AW = $clog2(DEPTH_LANES),
    localparam int unsigned CW = AW + 1
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          in_wide,
    input  logic          out_wide,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    logic [CW-1:0] wstep;
    logic [CW-1:0] rstep;
    logic [CW:0]   room_need;

    assign wstep     = in_wide  ? CW'(2) : CW'(1);
    assign rstep     = out_wide ? CW'(2) : CW'(1);
    assign room_need = {1'b0, st_q.count} + {1'b0, wstep};
    assign full      = room_need > (CW+1)'(DEPTH_LANES);
    assign empty     = st_q.count < rstep;
    assign wr_go     = wr_en && !full;
    assign rd_go     = rd_en && !empty;

    always_comb begin
        st_d = st_q;
        if (wr_go) begin
            st_d.wptr = st_q.wptr + AW'(wstep);
        end
        if (rd_go) begin
            st_d.rptr = st_q.rptr + AW'(rstep);
        end
        st_d.count = st_q.count + (wr_go ? wstep : CW'(0)) - (rd_go ? rstep : CW'(0));
        if (mrst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wptr = st_q.wptr;
    assign rptr = st_q.rptr;

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (mrst)
        st_q.count <= CW'(DEPTH_LANES));

    assert_full_drops_write_R9: assert property (@(posedge clk) disable iff (mrst)
        full |=> st_q.wptr == $past(st_q.wptr));

    assert_empty_drops_read_R9: assert property (@(posedge clk) disable iff (mrst)
        empty |=> st_q.rptr == $past(st_q.rptr));

    // R6/R5: a wide side always stays on a lane pair boundary
    assert_wide_wr_aligned_R6: assert property (@(posedge clk) disable iff (mrst)
        in_wide |-> st_q.wptr[0] == 1'b0);

    assert_wide_rd_aligned_R6: assert property (@(posedge clk) disable iff (mrst)
        out_wide |-> st_q.rptr[0] == 1'b0);

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (mrst)
        !(full && empty));

endmodule

// File: rtl/bmf_fifo.sv
module bmf_fifo
    import bmf_pkg::*;
#(
    parameter int unsigned DEPTH_LANES = 64,
    localparam int unsigned AW = $clog2(DEPTH_LANES)
) (
    input  logic        clk,
    input  logic        mrst,
    input  logic        cfg_in_wide,
    input  logic        cfg_out_wide,
    input  logic        cfg_big_end,
    input  logic        wr_en,
    input  logic [17:0] wr_data,
    input  logic        rd_en,
    output logic [17:0] rd_data,
    output logic        full,
    output logic        empty
);

    bmf_cfg_t      cfg_pins;
    bmf_cfg_t      cfg;
    logic          wr_go, rd_go;
    logic [AW-1:0] wptr, rptr;
    lane_t         wlane0, wlane1, rlane0, rlane1;
    word_t         rd_word;
    word_t         rd_data_d, rd_data_q;

    assign cfg_pins = '{in_wide: cfg_in_wide, out_wide: cfg_out_wide, big_end: cfg_big_end};

    bmf_cfg_latch u_cfg (
        .clk    (clk),
        .mrst   (mrst),
        .cfg_in (cfg_pins),
        .cfg    (cfg)
    );

    bmf_ptr_ctrl #(.DEPTH_LANES(DEPTH_LANES)) u_ptr (
        .clk      (clk),
        .mrst     (mrst),
        .in_wide  (cfg.in_wide),
        .out_wide (cfg.out_wide),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .wptr     (wptr),
        .rptr     (rptr),
        .full     (full),
        .empty    (empty)
    );

    // Split the write word into queue-ordered lanes
    always_comb begin
        if (cfg.in_wide) begin
            wlane0 = lead_lane(wr_data, cfg.big_end);
            wlane1 = trail_lane(wr_data, cfg.big_end);
        end else begin
            wlane0 = wr_data[LANE_W-1:0];
            wlane1 = wr_data[LANE_W-1:0];
        end
    end

    bmf_lane_store #(.DEPTH_LANES(DEPTH_LANES)) u_store (
        .clk     (clk),
        .we      (wr_go),
        .we_pair (cfg.in_wide),
        .waddr   (wptr),
        .wlane0  (wlane0),
        .wlane1  (wlane1),
        .raddr   (rptr),
        .rlane0  (rlane0),
        .rlane1  (rlane1)
    );

    // Join queue-ordered lanes into the read word
    assign rd_word = cfg.out_wide ? join_lanes(rlane0, rlane1, cfg.big_end)
                                  : {{LANE_W{1'b0}}, rlane0};

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_go) begin
            rd_data_d = rd_word;
        end
        if (mrst) begin
            rd_data_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rd_data_q <= rd_data_d;
    end

    assign rd_data = rd_data_q;

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (mrst)
        !rd_go |=> $stable(rd_data_q));

    assert_narrow_upper_zero_R10: assert property (@(posedge clk) disable iff (mrst)
        !cfg.out_wide |-> rd_data_q[17:9] == 9'd0);

endmodule

// File: tb/sim_bmf_fifo.sv
module sim_bmf_fifo;

    localparam int unsigned DEPTH = 8;
    localparam logic [8:0] P = 9'h1A5;
    localparam logic [8:0] Q = 9'h0C3;
    localparam logic [8:0] Z = 9'h000;

    typedef struct packed {
        logic        iw;
        logic        ow;
        logic        be;
        logic [1:0]  nw;
        logic [1:0]  nr;
        logic [17:0] w0;
        logic [17:0] w1;
        logic [17:0] e0;
        logic [17:0] e1;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{1'b0, 1'b0, 1'b1, 2'd2, 2'd2, {Z,P}, {Z,Q}, {Z,P}, {Z,Q}},
        '{1'b0, 1'b0, 1'b0, 2'd2, 2'd2, {Z,P}, {Z,Q}, {Z,P}, {Z,Q}},
        '{1'b0, 1'b1, 1'b1, 2'd2, 2'd1, {Z,P}, {Z,Q}, {P,Q}, {Z,Z}},
        '{1'b0, 1'b1, 1'b0, 2'd2, 2'd1, {Z,P}, {Z,Q}, {Q,P}, {Z,Z}},
        '{1'b1, 1'b0, 1'b1, 2'd1, 2'd2, {P,Q}, {Z,Z}, {Z,P}, {Z,Q}},
        '{1'b1, 1'b0, 1'b0, 2'd1, 2'd2, {P,Q}, {Z,Z}, {Z,Q}, {Z,P}},
        '{1'b1, 1'b1, 1'b1, 2'd2, 2'd2, {P,Q}, {Q,P}, {P,Q}, {Q,P}},
        '{1'b1, 1'b1, 1'b0, 2'd2, 2'd2, {P,Q}, {Q,P}, {P,Q}, {Q,P}}
    };

    logic        clk = 1'b0;
    logic        mrst = 1'b1;
    logic        cfg_in_wide = 1'b0;
    logic        cfg_out_wide = 1'b0;
    logic        cfg_big_end = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [17:0] rd_data;
    logic        full, empty;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bmf_fifo #(.DEPTH_LANES(DEPTH)) u0 (
        .clk(clk), .mrst(mrst),
        .cfg_in_wide(cfg_in_wide), .cfg_out_wide(cfg_out_wide), .cfg_big_end(cfg_big_end),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .full(full), .empty(empty)
    );

    task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_mrst(input logic iw, input logic ow, input logic be);
        @(negedge clk);
        mrst = 1'b1; cfg_in_wide = iw; cfg_out_wide = ow; cfg_big_end = be;
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        mrst = 1'b0;
        cfg_in_wide = ~iw; cfg_out_wide = ~ow; cfg_big_end = ~be;
    endtask

    task automatic wr(input logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(output logic [17:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic string mode_tag(input logic iw, input logic ow);
        if (iw && ow) return "R3";
        if (!iw && !ow) return "R4";
        if (iw) return "R5";
        return "R6";
    endfunction

    initial begin
        vec_t v;
        logic [17:0] got;

        // R1: state during and right after master reset
        repeat (2) @(negedge clk);
        chk("R1 empty in reset", {17'd0, empty}, 18'd1);
        chk("R1 full in reset", {17'd0, full}, 18'd0);
        do_mrst(1'b1, 1'b1, 1'b1);
        chk("R1 empty after reset", {17'd0, empty}, 18'd1);
        chk("R1 full after reset", {17'd0, full}, 18'd0);
        chk("R1 rd_data after reset", rd_data, 18'd0);

        // Table: byte order for every width mode and both orders
        for (int i = 0; i < 8; i++) begin
            v = TBL[i];
            do_mrst(v.iw, v.ow, v.be);
            wr(v.w0);
            if (v.nw == 2'd2) wr(v.w1);
            rd(got);
            chk($sformatf("%s row%0d word0", mode_tag(v.iw, v.ow), i), got, v.e0);
            if (v.nr == 2'd2) begin
                rd(got);
                chk($sformatf("%s row%0d word1", mode_tag(v.iw, v.ow), i), got, v.e1);
            end
            chk($sformatf("R7 row%0d empty after drain", i), {17'd0, empty}, 18'd1);
        end

        // R2: configuration inputs flipped after reset are ignored
        do_mrst(1'b1, 1'b0, 1'b1);
        wr({P, Q});
        rd(got);
        chk("R2 latched split order", got, {Z, P});

        // R7 and R9: half a wide word stored counts as empty; read dropped
        do_mrst(1'b0, 1'b1, 1'b1);
        wr({Z, Q});
        chk("R7 one lane is empty for wide read", {17'd0, empty}, 18'd1);
        rd(got);
        chk("R9 read while empty keeps rd_data", got, 18'd0);
        wr({Z, P});
        chk("R7 two lanes not empty", {17'd0, empty}, 18'd0);
        rd(got);
        chk("R6 pack after dropped read", got, {Q, P});

        // R8 and R9: wide write side holds DEPTH/2 words
        do_mrst(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) wr(18'(k + 1));
        chk("R8 not full with one pair free", {17'd0, full}, 18'd0);
        wr(18'd4);
        chk("R8 full at capacity", {17'd0, full}, 18'd1);
        wr(18'h3FFFF);
        for (int k = 0; k < 4; k++) begin
            rd(got);
            chk($sformatf("R9 word %0d after dropped write", k), got, 18'(k + 1));
        end
        chk("R9 dropped write not stored", {17'd0, empty}, 18'd1);
        rd(got);
        chk("R9 read on empty holds", got, 18'd4);

        // R8: narrow write side holds DEPTH lanes
        do_mrst(1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 7; k++) wr(18'(k));
        chk("R8 narrow not full at 7 lanes", {17'd0, full}, 18'd0);
        wr(18'd7);
        chk("R8 narrow full at 8 lanes", {17'd0, full}, 18'd1);
        rd(got);
        chk("R6 first pair big order", got, {9'd0, 9'd1});

        // R11 and R10: simultaneous write and read in narrow mode
        do_mrst(1'b0, 1'b0, 1'b0);
        wr({Z, P});
        @(negedge clk);
        chk("R10 rd_data unchanged before read", rd_data, 18'd0);
        wr_en = 1'b1; wr_data = {Z, Q}; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 data visible after accepting edge", rd_data, {Z, P});
        chk("R11 one lane left after write+read", {17'd0, empty}, 18'd0);
        rd(got);
        chk("R11 second lane intact", got, {Z, Q});
        chk("R11 empty after final read", {17'd0, empty}, 18'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule